// File: doc/BRIEF.md
# Systolic Horner Cosine Sequence Generator

This block streams samples of cos(n·w + φ) at one sample per clock, given only a digital frequency word w and a phase offset φ. It uses a linear systolic chain of three identical cells. Each cell evaluates one nested step of the four-term even power series 1 − x²/2 + x⁴/24 − x⁶/720, taken in powers of x². Each cell keeps its own running copy of the argument, which it advances by w every cycle. It rebuilds the series coefficient for its step from the coefficient of its left neighbour, using a small integer product in place of a stored constant or a divider. The data that flows from cell to cell passes through registers, so the chain is fully pipelined.

A stream starts on the first clock in which `runIn` is seen high after an idle cycle or after reset. On that edge the block latches `freqIn` and `phaseIn`, and the stream continues for as long as `runIn` stays high. Setting the phase to −π/2 turns the cosine stream into a sine stream. All values are signed fixed point with FRAC_W fraction bits. The argument wraps at ±π.

Top module: `cos_seq_gen`

## Requirements
- R1: A synchronous reset clears the pipeline. On the cycle after an edge that samples `rst` high, `sampleValid` is 0 and `sampleOut` is 0.
- R2: The edge that first samples `runIn` high after an idle cycle latches `freqIn` and `phaseIn`. Sample n = 0 of that stream is evaluated at an argument equal to the latched phase. With w = 0 and φ = 0, every sample equals 1.0, which is 2^FRAC_W.
- R3: `sampleValid` after rising edge k equals `runIn` as sampled at edge k−3, so the first sample appears three edges after the launching edge. A run that is sampled high for L cycles produces exactly L consecutive valid samples, one per clock.
- R4: Sample n equals P(x) = 1 − x²/2 + x⁴/24 − x⁶/720 to within 6e-4, where x is the argument of R5 divided by 2^FRAC_W. A valid sample always lies between −1.25 and 1.0078.
- R5: The argument of sample n is (n·w + φ) reduced modulo 2Π into [−Π, Π), where Π = round(π·2^FRAC_W). Both w and φ must lie in [−Π, Π). A frequency at or near ±Π exercises the wrap on every sample.
- R6: A phase of −round(π/2·2^FRAC_W) yields sin(n·w) within 2e-3 for small arguments.
- R7: Changes on `freqIn` or `phaseIn` while `runIn` stays high have no effect on the running stream.
- R8: After at least one idle cycle, a new run restarts at n = 0 with newly latched values, even while samples of the previous run are still draining.
- R9: While `sampleValid` is 0, `sampleOut` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| runIn | input | 1 | High to run a stream; its first high cycle launches the stream |
| freqIn | input | DATA_W | Signed frequency word w, FRAC_W fraction bits, radians per sample |
| phaseIn | input | DATA_W | Signed phase offset φ, FRAC_W fraction bits, radians |
| sampleOut | output | DATA_W | Signed sample, FRAC_W fraction bits |
| sampleValid | output | 1 | High when `sampleOut` carries a new sample |

## Verification
The block can drain the tail of one stream while the next stream launches in the same cycle. That cycle holds a fresh latch of frequency and phase, with the first-cell accumulator restarting from zero, while the last cell is still emitting an old sample. The bench provokes this with runs separated by a single idle cycle, and with a run only one cycle long. It judges the result from the cycle-exact valid pattern and from value checks that pair each valid burst with the parameters in force when that burst was launched. Mid-run changes to the frequency and phase inputs are driven inside the same streams, so that the launch capture and the ignore rule are tested against each other.

// File: rtl/cos_seq_pkg.sv
`timescale 1ns/1ps
package cos_seq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // first active cycle of a run: latch frequency and phase
    logic issue;    // a sample token enters the array on this edge
  } seq_strobe_t;

  function automatic longint factorial(input int k);
    longint acc;
    acc = 1;
    for (int i = 2; i <= k; i++) acc = acc * longint'(i);
    return acc;
  endfunction

  // round(pi * 2^fw)
  function automatic longint fixedPi(input int fw);
    real scale;
    scale = 1.0;
    for (int i = 0; i < fw; i++) scale = scale * 2.0;
    return longint'($rtoi(3.141592653589793 * scale + 0.5));
  endfunction

  // round(2^frac / den)
  function automatic longint fixedRecip(input int frac, input longint den);
    real scale;
    scale = 1.0;
    for (int i = 0; i < frac; i++) scale = scale * 2.0;
    return longint'($rtoi(scale / real'(den) + 0.5));
  endfunction

endpackage

// File: rtl/cos_seq_ctrl.sv
`timescale 1ns/1ps
module cos_seq_ctrl
  import cos_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        runIn,
  output seq_strobe_t strobe
);

  logic runQ;

  always_ff @(posedge clk) begin
    if (rst) runQ <= 1'b0;
    else     runQ <= runIn;
  end

  always_comb begin
    strobe.capture = runIn & ~runQ;
    strobe.issue   = runIn;
  end

endmodule

// File: rtl/cos_seq_cell.sv
`timescale 1ns/1ps
module cos_seq_cell #(
  parameter int DATA_W    = 26,
  parameter int FRAC_W    = 20,
  parameter int COEF_FRAC = 30,
  parameter int P_W       = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  actIn,
  input  logic signed [DATA_W-1:0] freqIn,
  input  logic signed [DATA_W-1:0] phaseIn,
  input  logic signed [DATA_W-1:0] yIn,
  input  logic signed [DATA_W+COEF_FRAC-FRAC_W-1:0] fIn,
  input  logic [P_W-1:0]        pIn,
  input  logic                  uNegIn,
  output logic                  actOut,
  output logic signed [DATA_W-1:0] freqOut,
  output logic signed [DATA_W-1:0] phaseOut,
  output logic signed [DATA_W-1:0] yOut,
  output logic signed [DATA_W+COEF_FRAC-FRAC_W-1:0] fOut,
  output logic [P_W-1:0]        pOut,
  output logic                  uNegOut
);
  import cos_seq_pkg::*;

  localparam int SHIFT  = COEF_FRAC - FRAC_W;
  localparam int COEF_W = DATA_W + SHIFT;
  localparam int PROD_W = 2 * DATA_W;
  localparam logic signed [DATA_W:0] PI_Q     = (DATA_W+1)'(fixedPi(FRAC_W));
  localparam logic signed [DATA_W:0] TWO_PI_Q = PI_Q + PI_Q;
  localparam logic signed [COEF_W-1:0] HALF_LSB = COEF_W'(longint'(1) << (SHIFT - 1));

  function automatic logic signed [DATA_W-1:0] wrapAdd(
    input logic signed [DATA_W-1:0] a,
    input logic signed [DATA_W-1:0] b
  );
    logic signed [DATA_W:0] s;
    s = {a[DATA_W-1], a} + {b[DATA_W-1], b};
    if (s >= PI_Q)       s = s - TWO_PI_Q;
    else if (s < -PI_Q)  s = s + TWO_PI_Q;
    return s[DATA_W-1:0];
  endfunction

  function automatic logic signed [PROD_W-1:0] widen(input logic signed [DATA_W-1:0] v);
    return {{DATA_W{v[DATA_W-1]}}, v};
  endfunction

  // Local argument accumulator and phased argument
  logic signed [DATA_W-1:0] accQ;
  logic signed [DATA_W-1:0] argNow;
  assign argNow = wrapAdd(accQ, phaseIn);

  // Square of argument
  logic signed [PROD_W-1:0] sqFull;
  logic signed [DATA_W-1:0] argSq;
  assign sqFull = widen(argNow) * widen(argNow);
  assign argSq  = sqFull[FRAC_W +: DATA_W];

  // Horner multiply
  logic signed [PROD_W-1:0] hornFull;
  logic signed [DATA_W-1:0] hornScaled;
  assign hornFull   = widen(yIn) * widen(argSq);
  assign hornScaled = hornFull[FRAC_W +: DATA_W];

  // Coefficient regeneration: f * p * (p-1)
  logic [P_W-1:0]           pPair;
  logic signed [COEF_W-1:0] pPairExt;
  logic signed [COEF_W-1:0] fNext;
  logic signed [COEF_W-1:0] fRounded;
  logic signed [DATA_W-1:0] termMag;
  logic                     uNegNext;
  logic signed [DATA_W-1:0] yNext;

  assign pPair    = pIn * (pIn - P_W'(1));
  assign pPairExt = signed'(COEF_W'(pPair));
  assign fNext    = pPairExt * fIn;
  assign fRounded = fNext + HALF_LSB;
  assign termMag  = fRounded[SHIFT +: DATA_W];
  assign uNegNext = ~uNegIn;
  assign yNext    = hornScaled + (uNegNext ? -termMag : termMag);

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ     <= '0;
      actOut   <= 1'b0;
      freqOut  <= '0;
      phaseOut <= '0;
      yOut     <= '0;
      fOut     <= '0;
      pOut     <= '0;
      uNegOut  <= 1'b0;
    end else begin
      accQ     <= actIn ? wrapAdd(accQ, freqIn) : '0;
      actOut   <= actIn;
      freqOut  <= freqIn;
      phaseOut <= phaseIn;
      if (actIn) begin
        yOut    <= yNext;
        fOut    <= fNext;
        pOut    <= pIn - P_W'(2);
        uNegOut <= uNegNext;
      end
    end
  end

endmodule

// File: rtl/cos_seq_datapath.sv
`timescale 1ns/1ps
module cos_seq_datapath
  import cos_seq_pkg::*;
#(
  parameter int DATA_W    = 26,
  parameter int FRAC_W    = 20,
  parameter int COEF_FRAC = 30,
  parameter int N_TERMS   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  seq_strobe_t              strobe,
  input  logic signed [DATA_W-1:0] freqIn,
  input  logic signed [DATA_W-1:0] phaseIn,
  output logic signed [DATA_W-1:0] sampleOut,
  output logic                     sampleValid,
  output logic signed [DATA_W-1:0] latchedFreq,
  output logic signed [DATA_W-1:0] latchedPhase
);

  localparam int N_CELLS = N_TERMS - 1;
  localparam int COEF_W  = DATA_W + COEF_FRAC - FRAC_W;
  localparam int P_W     = 8;
  localparam int TOP_P   = 2 * N_CELLS;
  localparam longint TOP_FACT  = factorial(TOP_P);
  localparam longint TOP_F     = fixedRecip(COEF_FRAC, TOP_FACT);
  localparam longint TOP_Y_MAG = fixedRecip(FRAC_W, TOP_FACT);
  localparam bit     TOP_NEG   = (N_CELLS % 2) == 1;

  logic headAct;

  always_ff @(posedge clk) begin
    if (rst) begin
      headAct      <= 1'b0;
      latchedFreq  <= '0;
      latchedPhase <= '0;
    end else begin
      headAct <= strobe.issue;
      if (strobe.capture) begin
        latchedFreq  <= freqIn;
        latchedPhase <= phaseIn;
      end
    end
  end

  logic                     actBus   [N_CELLS+1];
  logic signed [DATA_W-1:0] freqBus  [N_CELLS+1];
  logic signed [DATA_W-1:0] phaseBus [N_CELLS+1];
  logic signed [DATA_W-1:0] yBus     [N_CELLS+1];
  logic signed [COEF_W-1:0] fBus     [N_CELLS+1];
  logic [P_W-1:0]           pBus     [N_CELLS+1];
  logic                     uNegBus  [N_CELLS+1];

  // Boundary values entering the first cell
  assign actBus[0]   = headAct;
  assign freqBus[0]  = latchedFreq;
  assign phaseBus[0] = latchedPhase;
  assign yBus[0]     = TOP_NEG ? -DATA_W'(TOP_Y_MAG) : DATA_W'(TOP_Y_MAG);
  assign fBus[0]     = COEF_W'(TOP_F);
  assign pBus[0]     = P_W'(TOP_P);
  assign uNegBus[0]  = TOP_NEG;

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    cos_seq_cell #(
      .DATA_W(DATA_W), .FRAC_W(FRAC_W), .COEF_FRAC(COEF_FRAC), .P_W(P_W)
    ) u_cell (
      .clk      (clk),
      .rst      (rst),
      .actIn    (actBus[k]),
      .freqIn   (freqBus[k]),
      .phaseIn  (phaseBus[k]),
      .yIn      (yBus[k]),
      .fIn      (fBus[k]),
      .pIn      (pBus[k]),
      .uNegIn   (uNegBus[k]),
      .actOut   (actBus[k+1]),
      .freqOut  (freqBus[k+1]),
      .phaseOut (phaseBus[k+1]),
      .yOut     (yBus[k+1]),
      .fOut     (fBus[k+1]),
      .pOut     (pBus[k+1]),
      .uNegOut  (uNegBus[k+1])
    );
  end

  assign sampleOut   = yBus[N_CELLS];
  assign sampleValid = actBus[N_CELLS];

  logic unusedTail;
  assign unusedTail = ^{freqBus[N_CELLS], phaseBus[N_CELLS], fBus[N_CELLS],
                        pBus[N_CELLS], uNegBus[N_CELLS]};

endmodule

// File: rtl/cos_seq_gen.sv
`timescale 1ns/1ps
module cos_seq_gen
  import cos_seq_pkg::*;
#(
  parameter int DATA_W    = 26,
  parameter int FRAC_W    = 20,
  parameter int COEF_FRAC = 30,
  parameter int N_TERMS   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     runIn,
  input  logic signed [DATA_W-1:0] freqIn,
  input  logic signed [DATA_W-1:0] phaseIn,
  output logic signed [DATA_W-1:0] sampleOut,
  output logic                     sampleValid
);

  seq_strobe_t              strobe;
  logic signed [DATA_W-1:0] latchedFreq;
  logic signed [DATA_W-1:0] latchedPhase;

  cos_seq_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .runIn  (runIn),
    .strobe (strobe)
  );

  cos_seq_datapath #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .COEF_FRAC(COEF_FRAC), .N_TERMS(N_TERMS)
  ) u_datapath (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .freqIn       (freqIn),
    .phaseIn      (phaseIn),
    .sampleOut    (sampleOut),
    .sampleValid  (sampleValid),
    .latchedFreq  (latchedFreq),
    .latchedPhase (latchedPhase)
  );

endmodule

// File: rtl/cos_seq_gen_checker.sv
`timescale 1ns/1ps
module cos_seq_gen_checker #(
  parameter int DATA_W = 26,
  parameter int FRAC_W = 20
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     runIn,
  input logic signed [DATA_W-1:0] freqIn,
  input logic signed [DATA_W-1:0] phaseIn,
  input logic signed [DATA_W-1:0] sampleOut,
  input logic                     sampleValid,
  input logic signed [DATA_W-1:0] latchedFreq,
  input logic signed [DATA_W-1:0] latchedPhase
);

  localparam logic signed [DATA_W-1:0] LOW_LIM  = -(DATA_W'(5) <<< (FRAC_W - 2));
  localparam logic signed [DATA_W-1:0] HIGH_LIM = (DATA_W'(1) <<< FRAC_W) + (DATA_W'(1) <<< (FRAC_W - 7));

  logic [3:0] runPipe;
  logic       runPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      runPipe <= '0;
      runPrev <= 1'b0;
    end else begin
      runPipe <= {runPipe[2:0], runIn};
      runPrev <= runIn;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!sampleValid && sampleOut == '0));

  a_r2_launch_capture: assert property (@(posedge clk) disable iff (rst)
    (runIn && !runPrev) |=> (latchedFreq == $past(freqIn) && latchedPhase == $past(phaseIn)));

  a_r3_valid_latency: assert property (@(posedge clk) disable iff (rst)
    sampleValid == runPipe[3]);

  a_r4_sample_bounds: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> (sampleOut >= LOW_LIM && sampleOut <= HIGH_LIM));

  a_r7_freq_held: assert property (@(posedge clk) disable iff (rst)
    (runIn && runPrev) |=> $stable(latchedFreq));

  a_r7_phase_held: assert property (@(posedge clk) disable iff (rst)
    (runIn && runPrev) |=> $stable(latchedPhase));

  a_r9_hold_output: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |-> $stable(sampleOut));

endmodule

bind cos_seq_gen cos_seq_gen_checker #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_checker (
  .clk          (clk),
  .rst          (rst),
  .runIn        (runIn),
  .freqIn       (freqIn),
  .phaseIn      (phaseIn),
  .sampleOut    (sampleOut),
  .sampleValid  (sampleValid),
  .latchedFreq  (latchedFreq),
  .latchedPhase (latchedPhase)
);

// File: tb/cos_seq_gen_bench.sv
`timescale 1ns/1ps
module cos_seq_gen_bench;

  localparam int  DW = 26;
  localparam int  FW = 20;
  localparam real SCALE = 1048576.0;
  localparam longint WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic runIn = 1'b0;
  logic signed [DW-1:0] freqIn = '0;
  logic signed [DW-1:0] phaseIn = '0;
  logic signed [DW-1:0] sampleOut;
  logic sampleValid;

  always #2 clk = ~clk;

  cos_seq_gen u_cos_seq_gen (
    .clk(clk), .rst(rst), .runIn(runIn), .freqIn(freqIn), .phaseIn(phaseIn),
    .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit monOn = 0;

  longint piQ;
  initial piQ = longint'($rtoi(3.141592653589793 * SCALE + 0.5));

  // Stream parameter queue (launch order)
  longint qW [0:63];
  longint qP [0:63];
  int     qK [0:63];
  int     wrIdx = 0;
  int     rdIdx = 0;

  function automatic real polyModel(input real x);
    real x2;
    x2 = x * x;
    return 1.0 - x2 / 2.0 + x2 * x2 / 24.0 - x2 * x2 * x2 / 720.0;
  endfunction

  function automatic longint reduceArg(input longint t);
    longint twoPi, m;
    twoPi = 2 * piQ;
    m = t % twoPi;
    if (m >= piQ) m = m - twoPi;
    else if (m < -piQ) m = m + twoPi;
    return m;
  endfunction

  task automatic checkReal(input string tag, input real act, input real exp, input real tol);
    checks++;
    if ((act - exp > tol) || (exp - act > tol)) begin
      fails++;
      $display("FAIL %s actual=%f expected=%f", tag, act, exp);
    end
  endtask

  task automatic checkInt(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected valid: runIn delayed by the pipeline (R3)
  logic [3:0] expV;
  always @(posedge clk) begin
    if (rst) expV <= '0;
    else     expV <= {expV[2:0], runIn};
  end

  // Output monitor
  bit     prevValid = 0;
  longint lastOut = 0;
  longint sIdx = 0;
  longint curW = 0, curP = 0;
  int     curK = 0;

  always @(negedge clk) begin
    if (!rst && monOn) begin
      checkInt("R3 valid timing", longint'(sampleValid), longint'(expV[3]));
      if (sampleValid) begin
        real got, want, xr;
        longint argQ;
        if (!prevValid) begin
          sIdx = 0;
          curW = qW[rdIdx]; curP = qP[rdIdx]; curK = qK[rdIdx];
          rdIdx++;
        end else begin
          sIdx = sIdx + 1;
        end
        argQ = reduceArg(sIdx * curW + curP);
        xr   = real'(argQ) / SCALE;
        got  = real'(sampleOut) / SCALE;
        want = polyModel(xr);
        if (sIdx == 0) checkReal("R8 R2 first sample at phase", got, want, 6.0e-4);
        else case (curK)
          3:       checkReal("R7 mid-run input change ignored", got, want, 6.0e-4);
          4:       checkReal("R5 argument wrap", got, want, 6.0e-4);
          default: checkReal("R4 series value", got, want, 6.0e-4);
        endcase
        if (curK == 1) checkReal("R2 zero frequency gives one", got, 1.0, 1.0e-5);
        if (curK == 2) checkReal("R6 sine output", got, $sin(real'(sIdx * curW) / SCALE), 2.0e-3);
        lastOut = longint'(sampleOut);
      end else begin
        checkInt("R9 output held while idle", longint'(sampleOut), lastOut);
      end
      prevValid = sampleValid;
    end
  end

  task automatic runStream(input longint w, input longint ph, input int len,
                           input int gap, input int kind);
    @(negedge clk);
    qW[wrIdx] = w; qP[wrIdx] = ph; qK[wrIdx] = kind; wrIdx++;
    freqIn  = DW'(w);
    phaseIn = DW'(ph);
    runIn   = 1'b1;
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      if (kind == 3 && i == len / 2) begin
        freqIn  = ~freqIn;
        phaseIn = phaseIn + DW'(12345);
      end
    end
    @(negedge clk);
    runIn = 1'b0;
    for (int g = 1; g < gap; g++) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkInt("R1 reset valid", longint'(sampleValid), 0);
    checkInt("R1 reset sample", longint'(sampleOut), 0);
    rst = 1'b0;
    lastOut = 0;
    monOn = 1;
    repeat (2) @(negedge clk);

    // R2: zero frequency, zero phase
    runStream(0, 0, 6, 2, 1);
    // R6: sine by a -pi/2 phase
    runStream(104858, -1647100, 12, 1, 2);
    // R5: wrap every sample at the frequency extremes
    runStream(piQ - 1, 0, 10, 1, 4);
    runStream(-piQ, 300000, 8, 3, 4);
    // R7: inputs change in mid-run
    runStream(200000, 100000, 16, 2, 3);
    // R8 and R3: back-to-back runs with one idle cycle, single-cycle run
    runStream(-500000, -2000000, 5, 1, 0);
    runStream(900000, 1500000, 1, 1, 0);
    runStream(33000, -3000000, 7, 4, 0);

    // Random runs
    for (int s = 0; s < 12; s++) begin
      longint w, ph;
      int len, gap;
      w   = longint'($urandom_range(0, 32'(2 * piQ - 1))) - piQ;
      ph  = longint'($urandom_range(0, 32'(2 * piQ - 1))) - piQ;
      len = int'($urandom_range(1, 40));
      gap = int'($urandom_range(1, 3));
      runStream(w, ph, len, gap, (s % 3 == 0) ? 3 : 0);
    end

    repeat (10) @(negedge clk);
    checkInt("R3 every launched run produced samples", longint'(rdIdx), longint'(wrIdx));
    finishRun();
  end

endmodule